// File: doc/BRIEF.md
# Monitor Setup Stream Parser

This block turns a stream of setup bytes written by a bus master into the configuration registers of a channel monitor. A start-of-transaction pulse puts the parser in front of the configuration byte. That byte sets the interrupt enable and a 3-bit scan delay code, and it fires a one-cycle alarm-clear strobe for each channel. Threshold records follow it, three bytes each. Every record carries a 10-bit lower and a 10-bit upper trip level. The two values are packed across byte boundaries, with don't-care gaps between them.

Two inputs set how many records a transaction carries and which channels they belong to. The first is a 2-bit highest-channel select. The second is a differential-mode flag: in differential mode only even channels receive records, and each record programs a pair of channels. Both inputs are captured when the configuration byte is accepted. A channel's thresholds take effect only when its record is complete, and a single-cycle update pulse marks the change. Bus framing and acknowledge generation are handled elsewhere.

Top module: `mon_setup_parser`

## Requirements
- R1: After reset the delay code is 0, the interrupt enable is 0, no clear strobe or update pulse is active, every lower threshold is 0 and every upper threshold is 1023. The next accepted byte is taken as the configuration byte.
- R2: The configuration byte sets the delay code to its bits 3..1 and the interrupt enable to its bit 0. Both values are visible from the clock edge that accepts the byte, and they hold until the next configuration byte.
- R3: The configuration byte raises alarm_clr[i] when its bit 7-i is 1 (channel 0 uses bit 7, channel 3 uses bit 4). The strobe is high for exactly one cycle, starting at the edge that accepts the byte.
- R4: The three record bytes are laid out as follows. Byte 1 carries lower bits 9..4 in bits 5..0; its bits 7..6 are ignored. Byte 2 carries lower bits 3..0 in bits 7..4 and upper bits 9..8 in bits 1..0; its bits 3..2 are ignored. Byte 3 carries upper bits 7..0.
- R5: A channel's thresholds change only at the edge that accepts the third byte of its record, and thresh_upd pulses for one cycle at that edge. A record cut short by a start pulse leaves the previous values in place.
- R6: Without differential mode, records are taken for channels 0, 1, ... up to the select value, in ascending order.
- R7: In differential mode, records are taken only for even channels up to the select value. Each record writes the even channel and the odd channel above it, and both update bits pulse together.
- R8: The select and the mode flag are captured when the configuration byte is accepted. Changing them later in the transaction has no effect.
- R9: Bytes that arrive after the last expected record change no output.
- R10: A start pulse returns the parser to the configuration byte. A byte presented in the same cycle as the start pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pulse | input | 1 | Start of a setup transaction |
| byte_vld | input | 1 | byte_data is valid this cycle |
| byte_data | input | 8 | Setup byte |
| hi_chan_sel | input | 2 | Highest channel carrying a record |
| diff_mode | input | 1 | Channel-pair (differential) mode |
| delay_code | output | 3 | Scan delay code |
| irq_enable | output | 1 | Interrupt enable |
| alarm_clr | output | 4 | One-cycle alarm-clear strobes, one per channel |
| lo_thresh | output | 40 | Lower thresholds, 10 bits per channel, channel 0 in bits 9..0 |
| up_thresh | output | 40 | Upper thresholds, packed the same way |
| thresh_upd | output | 4 | One-cycle pulse per channel when its thresholds change |

## Verification
Every result of this block appears one clock edge after the byte that causes it. The configuration fields and clear strobes follow the edge that accepts the configuration byte, and the thresholds and update pulses follow the edge that accepts the third byte of a record. The bench drives each byte on a falling edge and reads the outputs on the next falling edge, half a cycle after the accepting edge. At that point the strobes and pulses are still high. It then checks one falling edge later that the strobes and pulses have dropped.

// File: rtl/mon_setup_pkg.sv
package mon_setup_pkg;
   localparam int THR_W    = 10;
   localparam int BYTE_W   = 8;
   localparam int REC_LEN  = 3;
   localparam int CLR_BITS = 4;

   typedef enum logic [1:0] {
      PH_CFG  = 2'd0,
      PH_REC  = 2'd1,
      PH_DONE = 2'd2
   } phase_t;
endpackage

// File: rtl/msp_sequencer.sv
module msp_sequencer
   import mon_setup_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int SEL_W = $clog2(NUM_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_pulse,
   input  logic             byte_vld,
   input  logic [SEL_W-1:0] hi_chan_sel,
   input  logic             diff_mode,
   output logic             cfg_take,
   output logic             rec_take,
   output logic [1:0]       rec_idx,
   output logic [SEL_W-1:0] cur_ch,
   output logic             diff_l
);
   phase_t           phase;
   logic [SEL_W-1:0] sel_l;
   logic [SEL_W:0]   next_ch;

   assign cfg_take = byte_vld && !start_pulse && (phase == PH_CFG);
   assign rec_take = byte_vld && !start_pulse && (phase == PH_REC);
   assign next_ch  = {1'b0, cur_ch} + (diff_l ? (SEL_W+1)'(2) : (SEL_W+1)'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_CFG;
         rec_idx <= '0;
         cur_ch  <= '0;
         sel_l   <= '0;
         diff_l  <= 1'b0;
      end else if (start_pulse) begin
         phase   <= PH_CFG;
         rec_idx <= '0;
         cur_ch  <= '0;
      end else if (cfg_take) begin
         phase   <= PH_REC;
         rec_idx <= '0;
         cur_ch  <= '0;
         sel_l   <= hi_chan_sel;
         diff_l  <= diff_mode;
      end else if (rec_take) begin
         if (rec_idx == 2'(REC_LEN-1)) begin
            rec_idx <= '0;
            if (next_ch > {1'b0, sel_l}) phase <= PH_DONE;
            else                          cur_ch <= next_ch[SEL_W-1:0];
         end else begin
            rec_idx <= rec_idx + 2'd1;
         end
      end
   end
endmodule

// File: rtl/msp_assembler.sv
module msp_assembler
   import mon_setup_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_take,
   input  logic              rec_take,
   input  logic [1:0]        rec_idx,
   input  logic [BYTE_W-1:0] byte_data,
   output logic [2:0]        delay_code,
   output logic              irq_enable,
   output logic [NUM_CH-1:0] alarm_clr,
   output logic              commit,
   output logic [THR_W-1:0]  commit_lo,
   output logic [THR_W-1:0]  commit_up
);
   logic [5:0] lo_hi;
   logic [3:0] lo_lo;
   logic [1:0] up_hi;
   logic [NUM_CH-1:0] clr_bits;

   always_comb begin
      for (int i = 0; i < NUM_CH; i++) clr_bits[i] = byte_data[BYTE_W-1-i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         delay_code <= '0;
         irq_enable <= 1'b0;
         alarm_clr  <= '0;
      end else begin
         alarm_clr <= cfg_take ? clr_bits : '0;
         if (cfg_take) begin
            delay_code <= byte_data[3:1];
            irq_enable <= byte_data[0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_hi <= '0;
         lo_lo <= '0;
         up_hi <= '0;
      end else if (rec_take) begin
         if (rec_idx == 2'd0) lo_hi <= byte_data[5:0];
         if (rec_idx == 2'd1) begin
            lo_lo <= byte_data[7:4];
            up_hi <= byte_data[1:0];
         end
      end
   end

   assign commit    = rec_take && (rec_idx == 2'(REC_LEN-1));
   assign commit_lo = {lo_hi, lo_lo};
   assign commit_up = {up_hi, byte_data};
endmodule

// File: rtl/msp_chan_regs.sv
module msp_chan_regs
   import mon_setup_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int SEL_W = $clog2(NUM_CH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    commit,
   input  logic [SEL_W-1:0]        cur_ch,
   input  logic                    diff_l,
   input  logic [THR_W-1:0]        commit_lo,
   input  logic [THR_W-1:0]        commit_up,
   output logic [NUM_CH*THR_W-1:0] lo_thresh,
   output logic [NUM_CH*THR_W-1:0] up_thresh,
   output logic [NUM_CH-1:0]       thresh_upd
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic wr;
      if (i % 2 == 1) begin : g_odd
         assign wr = commit && ((cur_ch == SEL_W'(i)) ||
                                (diff_l && cur_ch == SEL_W'(i-1)));
      end else begin : g_even
         assign wr = commit && (cur_ch == SEL_W'(i));
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_thresh[i*THR_W +: THR_W] <= '0;
            up_thresh[i*THR_W +: THR_W] <= '1;
            thresh_upd[i]               <= 1'b0;
         end else begin
            thresh_upd[i] <= wr;
            if (wr) begin
               lo_thresh[i*THR_W +: THR_W] <= commit_lo;
               up_thresh[i*THR_W +: THR_W] <= commit_up;
            end
         end
      end
   end
endmodule

// File: rtl/mon_setup_parser.sv
module mon_setup_parser
   import mon_setup_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int SEL_W = $clog2(NUM_CH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_pulse,
   input  logic                    byte_vld,
   input  logic [7:0]              byte_data,
   input  logic [SEL_W-1:0]        hi_chan_sel,
   input  logic                    diff_mode,
   output logic [2:0]              delay_code,
   output logic                    irq_enable,
   output logic [NUM_CH-1:0]       alarm_clr,
   output logic [NUM_CH*THR_W-1:0] lo_thresh,
   output logic [NUM_CH*THR_W-1:0] up_thresh,
   output logic [NUM_CH-1:0]       thresh_upd
);
   if (NUM_CH != 2 && NUM_CH != CLR_BITS) begin : g_bad_num_ch
      $error("NUM_CH must be 2 or 4");
   end

   logic             cfg_take, rec_take, commit, diff_l;
   logic [1:0]       rec_idx;
   logic [SEL_W-1:0] cur_ch;
   logic [THR_W-1:0] commit_lo, commit_up;

   msp_sequencer #(.NUM_CH(NUM_CH)) i_seq (
      .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .byte_vld(byte_vld),
      .hi_chan_sel(hi_chan_sel), .diff_mode(diff_mode), .cfg_take(cfg_take),
      .rec_take(rec_take), .rec_idx(rec_idx), .cur_ch(cur_ch), .diff_l(diff_l)
   );

   msp_assembler #(.NUM_CH(NUM_CH)) i_asm (
      .clk(clk), .rst_n(rst_n), .cfg_take(cfg_take), .rec_take(rec_take),
      .rec_idx(rec_idx), .byte_data(byte_data), .delay_code(delay_code),
      .irq_enable(irq_enable), .alarm_clr(alarm_clr), .commit(commit),
      .commit_lo(commit_lo), .commit_up(commit_up)
   );

   msp_chan_regs #(.NUM_CH(NUM_CH)) i_regs (
      .clk(clk), .rst_n(rst_n), .commit(commit), .cur_ch(cur_ch), .diff_l(diff_l),
      .commit_lo(commit_lo), .commit_up(commit_up), .lo_thresh(lo_thresh),
      .up_thresh(up_thresh), .thresh_upd(thresh_upd)
   );
endmodule

// File: rtl/msp_checker.sv
module msp_checker #(
   parameter int NUM_CH = 4,
   parameter int THR_W  = 10
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    byte_vld,
   input logic [2:0]              delay_code,
   input logic                    irq_enable,
   input logic [NUM_CH-1:0]       alarm_clr,
   input logic [NUM_CH*THR_W-1:0] lo_thresh,
   input logic [NUM_CH*THR_W-1:0] up_thresh,
   input logic [NUM_CH-1:0]       thresh_upd
);
   p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> $stable(delay_code) && $stable(irq_enable));

   p_clr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_clr != '0) |=> (alarm_clr == '0));

   p_clr_needs_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> (alarm_clr == '0));

   p_thr_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (thresh_upd == '0) |-> $stable(lo_thresh) && $stable(up_thresh));

   p_upd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (thresh_upd != '0) |=> (thresh_upd == '0));

   p_upd_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(thresh_upd) <= 2);
endmodule

bind mon_setup_parser msp_checker #(.NUM_CH(NUM_CH), .THR_W(mon_setup_pkg::THR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .delay_code(delay_code),
   .irq_enable(irq_enable), .alarm_clr(alarm_clr), .lo_thresh(lo_thresh),
   .up_thresh(up_thresh), .thresh_upd(thresh_upd)
);

// File: tb/test_mon_setup_parser.sv
module test_mon_setup_parser;
   localparam int NCH = 4;
   localparam int TW  = 10;
   localparam int NV  = 5;

   // vector: {sel[1:0], diff, cfg[7:0], lo[39:0], up[39:0]}, channel 0 in the low field
   localparam logic [90:0] VEC [NV] = '{
      {2'd3, 1'b0, 8'b1010_011_1, 10'h3C1, 10'h2AA, 10'h155, 10'h0AB, 10'h3FE, 10'h300, 10'h201, 10'h1F0},
      {2'd1, 1'b0, 8'b0101_101_0, 10'h011, 10'h022, 10'h033, 10'h044, 10'h111, 10'h122, 10'h133, 10'h144},
      {2'd3, 1'b1, 8'b1111_111_1, 10'h000, 10'h2F5, 10'h000, 10'h10F, 10'h000, 10'h3A2, 10'h000, 10'h27C},
      {2'd0, 1'b0, 8'b0000_000_0, 10'h000, 10'h000, 10'h000, 10'h3FF, 10'h000, 10'h000, 10'h000, 10'h000},
      {2'd1, 1'b1, 8'b0011_010_1, 10'h000, 10'h000, 10'h000, 10'h0C3, 10'h000, 10'h000, 10'h000, 10'h1E7}
   };

   logic clk = 0, rst_n = 0, start_pulse = 0, byte_vld = 0, diff_mode = 0;
   logic [7:0] byte_data = 0;
   logic [1:0] hi_chan_sel = 0;
   logic [2:0] delay_code;
   logic irq_enable;
   logic [NCH-1:0] alarm_clr, thresh_upd;
   logic [NCH*TW-1:0] lo_thresh, up_thresh;

   int checks = 0, errors = 0;
   logic [TW-1:0] exp_lo [NCH];
   logic [TW-1:0] exp_up [NCH];
   logic [2:0] exp_dly = 0;
   logic exp_irq = 0;

   always #10 clk = ~clk;

   mon_setup_parser i_mon_setup_parser (.*);

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk); byte_vld = 1; byte_data = b;
      @(negedge clk); byte_vld = 0; byte_data = 8'h00;
   endtask

   task automatic pulse_start();
      @(negedge clk); start_pulse = 1;
      @(negedge clk); start_pulse = 0;
   endtask

   task automatic check_all(input string tag);
      for (int c = 0; c < NCH; c++) begin
         chk({tag, " lo"}, 32'(lo_thresh[c*TW +: TW]), 32'(exp_lo[c]));
         chk({tag, " up"}, 32'(up_thresh[c*TW +: TW]), 32'(exp_up[c]));
      end
      chk({tag, " delay"}, 32'(delay_code), 32'(exp_dly));
      chk({tag, " irq"}, 32'(irq_enable), 32'(exp_irq));
   endtask

   task automatic send_cfg(input logic [7:0] cfg);
      logic [NCH-1:0] clr;
      for (int i = 0; i < NCH; i++) clr[i] = cfg[7-i];
      send_byte(cfg);
      exp_dly = cfg[3:1]; exp_irq = cfg[0];
      chk("R2 delay", 32'(delay_code), 32'(exp_dly));
      chk("R2 irq", 32'(irq_enable), 32'(exp_irq));
      chk("R3 clr strobe", 32'(alarm_clr), 32'(clr));
      @(negedge clk);
      chk("R3 clr drop", 32'(alarm_clr), 0);
   endtask

   // junk in the don't-care bits exercises R4
   task automatic send_rec(input int ch, input logic dm, input logic [9:0] lo, input logic [9:0] up);
      logic [NCH-1:0] m;
      m = dm ? (NCH'(3) << ch) : (NCH'(1) << ch);
      send_byte({2'b11, lo[9:4]});
      chk("R5 no upd b1", 32'(thresh_upd), 0);
      send_byte({lo[3:0], 2'b10, up[9:8]});
      chk("R5 no upd b2", 32'(thresh_upd), 0);
      send_byte(up[7:0]);
      chk("R6 R7 upd mask", 32'(thresh_upd), 32'(m));
      for (int c = 0; c < NCH; c++) if (m[c]) begin exp_lo[c] = lo; exp_up[c] = up; end
      @(negedge clk);
      chk("R5 upd drop", 32'(thresh_upd), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < NCH; c++) begin exp_lo[c] = '0; exp_up[c] = '1; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check_all("R1 reset");
      chk("R1 clr", 32'(alarm_clr), 0);
      chk("R1 upd", 32'(thresh_upd), 0);

      // table walk: R2, R3, R4, R5, R6, R7
      for (int v = 0; v < NV; v++) begin
         logic [1:0] sel; logic dm; logic [7:0] cfg; logic [39:0] lo, up;
         {sel, dm, cfg, lo, up} = VEC[v];
         hi_chan_sel = sel; diff_mode = dm;
         pulse_start();
         send_cfg(cfg);
         for (int ch = 0; ch <= int'(sel); ch += (dm ? 2 : 1))
            send_rec(ch, dm, lo[ch*TW +: TW], up[ch*TW +: TW]);
         check_all("R4 R6 R7 table");
      end

      // R9: trailing bytes after last record (sel=1 diff: one record) are ignored
      for (int k = 0; k < 4; k++) begin
         send_byte(8'hFF);
         chk("R9 upd", 32'(thresh_upd), 0);
      end
      check_all("R9 trailing");

      // R5: partial record then restart leaves thresholds
      hi_chan_sel = 2'd3; diff_mode = 0;
      pulse_start();
      send_cfg(8'b0000_100_1);
      send_byte(8'h3F);
      send_byte(8'hF3);
      pulse_start();
      check_all("R5 partial");

      // R10: byte in same cycle as start is ignored, then counters at config byte
      @(negedge clk); start_pulse = 1; byte_vld = 1; byte_data = 8'b1111_111_0;
      @(negedge clk); start_pulse = 0; byte_vld = 0;
      chk("R10 clr", 32'(alarm_clr), 0);
      check_all("R10 same cycle");
      send_cfg(8'b0000_001_1);
      send_rec(0, 0, 10'h2D2, 10'h0E1);
      check_all("R10 restart");

      // R8: select changed mid-transaction has no effect
      hi_chan_sel = 2'd1; diff_mode = 0;
      pulse_start();
      send_cfg(8'b0000_110_0);
      hi_chan_sel = 2'd3; diff_mode = 1;
      send_rec(0, 0, 10'h101, 10'h202);
      send_rec(1, 0, 10'h303, 10'h004);
      for (int k = 0; k < 3; k++) begin
         send_byte(8'h5A);
         chk("R8 upd", 32'(thresh_upd), 0);
      end
      check_all("R8 captured sel");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule